// File: doc/BRIEF.md
# Protected Flash Command Sequence Decoder

This block is a device-side model of a byte-wide parallel flash memory that guards its contents with a multi-write unlock protocol. A host drives chip enable, output enable, write enable, an address bus and a data bus. Reads return array bytes. Writes change nothing on their own. They feed a sequence decoder that starts a program, sector erase, chip erase, identifier entry or identifier exit only after the full unlock sequence has been received in the right order. Any write that breaks a sequence throws the decoder back to plain read mode.

A started program or erase runs for a fixed, parameterised number of clock cycles. Until it ends, every read returns a status byte instead of array data, so the host can poll for completion. In identifier mode, reads return a manufacturer code and a device code in place of the array. The array is a small parameterised register file split into equal sectors.

The read path is a plain strobe interface without back-pressure. A read cycle is always accepted. Its byte appears on `rdata` one clock later, and `rvalid` is high for exactly that one cycle. There is no ready signal, and a host must take the byte while `rvalid` is high.

Top module: `flash_cmd_dev`

## Requirements
- R1: After reset the array reads 0xFF everywhere, identifier mode is off, no operation is busy, and `rdata` and `rvalid` are 0.
- R2: Program: writes (0x5555,0xAA), (0x2AAA,0x55) and (0x5555,0xA0), followed by one write (A,D), start a program. When it completes, byte A holds its old value AND D.
- R3: Sector erase: writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then (SA,0x30) at any address SA. This sets every byte of the sector holding SA to 0xFF and leaves the other sectors unchanged. A sector is SECTOR_BYTES bytes, selected by the upper array index bits.
- R4: Chip erase uses the same first five writes followed by (0x5555,0x10), and it sets every array byte to 0xFF.
- R5: A write that does not match the next expected step of a sequence returns the decoder to its first step, starts nothing, and leaves identifier mode.
- R6: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x90) enter identifier mode. In this mode, reads at address 0x0000 return 0xBF, reads at 0x0001 return 0xD4 plus DENSITY_SEL, and reads at any other address return 0x00.
- R7: (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xF0) leave identifier mode. Any write accepted while an operation is busy is ignored, including this exit sequence.
- R8: A cycle counts as a write only when `ce_n`=0, `we_n`=0 and `oe_n`=1. An inhibited cycle neither advances nor aborts a sequence.
- R9: During a program, a read returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed, bit 6 is 0 on the first read and alternates on each later read, and bits 5..0 are 0.
- R10: During a sector or chip erase, status bit 7 is 0. Bit 6 toggles as in R9.
- R11: An operation is busy for PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES clock edges after the edge that accepts its final write. A read sampled on the last busy edge returns status, and a read sampled on the next edge returns array data.
- R12: A read cycle is `ce_n`=0, `oe_n`=0, `we_n`=1. Its byte appears on `rdata` after the next clock edge, and `rvalid` is high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all bus cycles are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data or status byte |
| rvalid | output | 1 | High for one cycle when `rdata` carries a read result |

## Verification
The hardest cases to reach from the ports are the ones that only exist inside the short busy window. These are the toggling status bit, a full command sequence that must be ignored, and an identifier exit that must not take effect. The stimulus reaches them by issuing reads or a complete command sequence on the clock edges right after the write that launched the operation, with busy lengths kept short. The bench then waits out the operation and reads back, through the normal read path, the array byte or identifier code that the ignored writes would have changed. The exact busy length is checked with one read timed for the last busy edge and a second read on the edge after it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OPC_PROGRAM = 8'hA0;
  localparam logic [7:0] OPC_ERASE   = 8'h80;
  localparam logic [7:0] OPC_SECTOR  = 8'h30;
  localparam logic [7:0] OPC_CHIP    = 8'h10;
  localparam logic [7:0] OPC_ID_IN   = 8'h90;
  localparam logic [7:0] OPC_ID_OUT  = 8'hF0;

  localparam logic [7:0] VENDOR_CODE = 8'hBF;
  localparam logic [7:0] PART_BASE   = 8'hD4;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_CHIP  = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    SQ_KEY1  = 3'd0,
    SQ_KEY2  = 3'd1,
    SQ_CMD   = 3'd2,
    SQ_DATA  = 3'd3,
    SQ_KEY3  = 3'd4,
    SQ_KEY4  = 3'd5,
    SQ_ERCMD = 3'd6
  } seq_e;

endpackage

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cyc,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              start,
  output op_e               start_kind,
  output logic [IDX_W-1:0]  start_idx,
  output logic [7:0]        start_data,
  output logic              id_mode,
  output seq_e              state
);

  seq_e state_q, state_d;
  logic id_q, id_d;
  logic at_a, at_b;

  assign at_a = (addr == ADDR_W'(UNLOCK_ADDR_A));
  assign at_b = (addr == ADDR_W'(UNLOCK_ADDR_B));

  always_comb begin
    state_d    = state_q;
    id_d       = id_q;
    start      = 1'b0;
    start_kind = OP_PROG;
    if (wr_cyc && !busy) begin
      state_d = SQ_KEY1;
      unique case (state_q)
        SQ_KEY1: begin
          if (at_a && wdata == KEY_FIRST) state_d = SQ_KEY2;
          else id_d = 1'b0;
        end
        SQ_KEY2: begin
          if (at_b && wdata == KEY_SECOND) state_d = SQ_CMD;
          else id_d = 1'b0;
        end
        SQ_CMD: begin
          if (at_a && wdata == OPC_PROGRAM)     state_d = SQ_DATA;
          else if (at_a && wdata == OPC_ERASE)  state_d = SQ_KEY3;
          else if (at_a && wdata == OPC_ID_IN)  id_d = 1'b1;
          else                                  id_d = 1'b0;
        end
        SQ_DATA: begin
          start      = 1'b1;
          start_kind = OP_PROG;
        end
        SQ_KEY3: begin
          if (at_a && wdata == KEY_FIRST) state_d = SQ_KEY4;
          else id_d = 1'b0;
        end
        SQ_KEY4: begin
          if (at_b && wdata == KEY_SECOND) state_d = SQ_ERCMD;
          else id_d = 1'b0;
        end
        SQ_ERCMD: begin
          if (wdata == OPC_SECTOR) begin
            start      = 1'b1;
            start_kind = OP_SECT;
          end else if (at_a && wdata == OPC_CHIP) begin
            start      = 1'b1;
            start_kind = OP_CHIP;
          end else begin
            id_d = 1'b0;
          end
        end
        default: id_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_KEY1;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign start_idx  = addr[IDX_W-1:0];
  assign start_data = wdata;
  assign id_mode    = id_q;
  assign state      = state_q;

endmodule

// File: rtl/flash_busy.sv
module flash_busy
  import flash_cmd_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int CNT_W       = 6,
  parameter int PROG_CYCLES = 8,
  parameter int SECT_CYCLES = 24,
  parameter int CHIP_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_kind,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [7:0]       start_data,
  input  logic             rd_cyc,
  output logic             busy,
  output logic             commit,
  output op_e              op_kind,
  output logic [IDX_W-1:0] op_idx,
  output logic [7:0]       op_data,
  output logic [7:0]       status,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LEN_PROG = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LEN_SECT = CNT_W'(SECT_CYCLES);
  localparam logic [CNT_W-1:0] LEN_CHIP = CNT_W'(CHIP_CYCLES);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;
  op_e              kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       data_q;
  logic [CNT_W-1:0] load_len;

  always_comb begin
    unique case (start_kind)
      OP_SECT: load_len = LEN_SECT;
      OP_CHIP: load_len = LEN_CHIP;
      default: load_len = LEN_PROG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      kind_q <= OP_PROG;
      idx_q  <= '0;
      data_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load_len;
      tog_q  <= 1'b0;
      kind_q <= start_kind;
      idx_q  <= start_idx;
      data_q <= start_data;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
      if (rd_cyc) tog_q <= ~tog_q;
    end
  end

  assign busy    = busy_q;
  assign commit  = busy_q && (cnt_q == CNT_W'(1));
  assign op_kind = kind_q;
  assign op_idx  = idx_q;
  assign op_data = data_q;
  assign cnt     = cnt_q;
  assign status  = {(kind_q == OP_PROG) ? ~data_q[7] : 1'b0, tog_q, 6'b0};

endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int SECTOR_BYTES = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  op_e                      kind,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [7:0]               data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [7:0]               rd_byte
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int SEC_W = $clog2(SECTOR_BYTES);

  logic [DEPTH-1:0][7:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic [7:0] cell_q;
    logic       hit_prog;
    logic       hit_erase;

    assign hit_prog  = commit && (kind == OP_PROG) && (idx == GI);
    assign hit_erase = commit && ((kind == OP_CHIP) ||
                       ((kind == OP_SECT) && (idx[IDX_W-1:SEC_W] == GI[IDX_W-1:SEC_W])));

    always_ff @(posedge clk) begin
      if (!rst_n)         cell_q <= 8'hFF;
      else if (hit_erase) cell_q <= 8'hFF;
      else if (hit_prog)  cell_q <= cell_q & data;
    end

    assign cells[g] = cell_q;
  end

  assign rd_byte = cells[rd_idx];

endmodule

// File: rtl/flash_cmd_dev.sv
module flash_cmd_dev
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MEM_DEPTH    = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int DENSITY_SEL  = 0,
  parameter int PROG_CYCLES  = 8,
  parameter int SECT_CYCLES  = 24,
  parameter int CHIP_CYCLES  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid
);

  localparam int IDX_W   = $clog2(MEM_DEPTH);
  localparam int LONG_PS = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int LONGEST = (LONG_PS > CHIP_CYCLES) ? LONG_PS : CHIP_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [7:0] PART_CODE = PART_BASE + 8'(DENSITY_SEL);

  logic             wr_cyc, rd_cyc;
  logic             start, busy, commit, id_mode;
  op_e              start_kind, op_kind;
  logic [IDX_W-1:0] start_idx, op_idx;
  logic [7:0]       start_data, op_data, status, arr_byte, id_byte;
  logic [CNT_W-1:0] cnt;
  seq_e             seq_state;

  assign wr_cyc = !ce_n && !we_n && oe_n;
  assign rd_cyc = !ce_n && !oe_n && we_n;

  flash_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cyc     (wr_cyc),
    .busy       (busy),
    .addr       (addr),
    .wdata      (wdata),
    .start      (start),
    .start_kind (start_kind),
    .start_idx  (start_idx),
    .start_data (start_data),
    .id_mode    (id_mode),
    .state      (seq_state)
  );

  flash_busy #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES), .CHIP_CYCLES(CHIP_CYCLES)
  ) u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (start_kind),
    .start_idx  (start_idx),
    .start_data (start_data),
    .rd_cyc     (rd_cyc),
    .busy       (busy),
    .commit     (commit),
    .op_kind    (op_kind),
    .op_idx     (op_idx),
    .op_data    (op_data),
    .status     (status),
    .cnt        (cnt)
  );

  flash_array #(.DEPTH(MEM_DEPTH), .SECTOR_BYTES(SECTOR_BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .kind    (op_kind),
    .idx     (op_idx),
    .data    (op_data),
    .rd_idx  (addr[IDX_W-1:0]),
    .rd_byte (arr_byte)
  );

  always_comb begin
    if (addr == ADDR_W'(0))      id_byte = VENDOR_CODE;
    else if (addr == ADDR_W'(1)) id_byte = PART_CODE;
    else                         id_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_cyc;
      if (rd_cyc) begin
        if (busy)         rdata <= status;
        else if (id_mode) rdata <= id_byte;
        else              rdata <= arr_byte;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_dev_chk.sv
module flash_cmd_dev_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cyc,
  input logic              rd_cyc,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt,
  input seq_e              seq_state,
  input logic              id_mode,
  input op_e               op_kind,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              rvalid
);

  p_inhibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cyc |=> ($stable(seq_state) && $stable(id_mode)));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cyc) |=> ($stable(seq_state) && $stable(id_mode)));

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CNT_W'(1)));

  p_read_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc |=> rvalid);

  p_no_read_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> !rvalid);

  p_erase_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && busy && op_kind != OP_PROG) |=> !rdata[7]);

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && busy && $past(rd_cyc && busy)) |=> (rdata[6] != $past(rdata[6])));

  p_vendor_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !busy && id_mode && addr == ADDR_W'(0)) |=> (rdata == VENDOR_CODE));

endmodule

bind flash_cmd_dev flash_cmd_dev_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_cyc    (wr_cyc),
  .rd_cyc    (rd_cyc),
  .busy      (busy),
  .cnt       (cnt),
  .seq_state (seq_state),
  .id_mode   (id_mode),
  .op_kind   (op_kind),
  .addr      (addr),
  .rdata     (rdata),
  .rvalid    (rvalid)
);

// File: tb/flash_cmd_dev_test.sv
`timescale 1ns/1ps
module flash_cmd_dev_test;

  localparam int P = 8;
  localparam int S = 24;
  localparam int C = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_dev #(.PROG_CYCLES(P), .SECT_CYCLES(S), .CHIP_CYCLES(C)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic bus(input logic c, input logic o, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    ce_n = c; oe_n = o; we_n = w; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus(1'b0, 1'b0, 1'b1, a, 8'h00);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    unlock();
    wr(16'h5555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_head();
    unlock();
    wr(16'h5555, 8'h80);
    unlock();
  endtask

  task automatic id_enter();
    unlock();
    wr(16'h5555, 8'h90);
  endtask

  task automatic id_exit();
    unlock();
    wr(16'h5555, 8'hF0);
  endtask

  task automatic t_reset();
    check("R1 rdata", rdata, 8'h00);
    check("R1 rvalid", {7'b0, rvalid}, 8'h00);
    rd_check("R1 erased array", 16'h0005, 8'hFF);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    rd(16'h0007, v);
    check("R12 rvalid after read", {7'b0, rvalid}, 8'h01);
    idle(1);
    check("R12 rvalid drops", {7'b0, rvalid}, 8'h00);
  endtask

  task automatic t_program();
    prog(16'h0010, 8'hA5);
    idle(P);
    rd_check("R2 program", 16'h0010, 8'hA5);
    prog(16'h0010, 8'h3C);
    idle(P);
    rd_check("R2 program ANDs", 16'h0010, 8'h24);
  endtask

  task automatic t_prog_status();
    prog(16'h0020, 8'h5A);
    rd_check("R9 status first", 16'h0020, 8'h80);
    rd_check("R9 status second", 16'h0020, 8'hC0);
    rd_check("R9 status third", 16'h0020, 8'h80);
    idle(P);
    rd_check("R9 data after busy", 16'h0020, 8'h5A);
  endtask

  task automatic t_busy_len();
    prog(16'h0030, 8'h0F);
    idle(P - 1);
    rd_check("R11 last busy edge", 16'h0030, 8'h80);
    rd_check("R11 first free edge", 16'h0030, 8'h0F);
    prog(16'h0031, 8'hF0);
    prog(16'h0032, 8'h00);
    idle(P);
    rd_check("R7 writes during busy ignored", 16'h0032, 8'hFF);
    rd_check("R11 first program kept", 16'h0031, 8'hF0);
  endtask

  task automatic t_sector();
    prog(16'h0040, 8'h11);
    idle(P);
    prog(16'h0080, 8'h22);
    idle(P);
    erase_head();
    wr(16'h0045, 8'h30);
    rd_check("R10 erase status first", 16'h0000, 8'h00);
    rd_check("R10 erase status toggled", 16'h0000, 8'h40);
    idle(S);
    rd_check("R3 sector erased", 16'h0040, 8'hFF);
    rd_check("R3 other sector kept", 16'h0080, 8'h22);
    rd_check("R3 sector zero kept", 16'h0010, 8'h24);
  endtask

  task automatic t_chip();
    erase_head();
    wr(16'h5555, 8'h10);
    rd_check("R10 chip erase status", 16'h0000, 8'h00);
    idle(C);
    rd_check("R4 chip erase 0x80", 16'h0080, 8'hFF);
    rd_check("R4 chip erase 0x10", 16'h0010, 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    unlock();
    wr(16'h5555, 8'h77);
    wr(16'h0050, 8'h00);
    idle(P + 2);
    rd_check("R5 bad command aborts", 16'h0050, 8'hFF);
    prog(16'h0060, 8'h12);
    idle(P);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h56);
    wr(16'h5555, 8'h10);
    idle(C);
    rd_check("R5 broken erase aborts", 16'h0060, 8'h12);
    id_enter();
    rd(16'h0000, v);
    check("R6 id before abort", v, 8'hBF);
    wr(16'h1234, 8'h00);
    rd_check("R5 abort leaves id mode", 16'h0000, 8'hFF);
  endtask

  task automatic t_id();
    id_enter();
    rd_check("R6 vendor code", 16'h0000, 8'hBF);
    rd_check("R6 part code", 16'h0001, 8'hD4);
    rd_check("R6 other address", 16'h0002, 8'h00);
    id_exit();
    rd_check("R7 exit to array", 16'h0000, 8'hFF);
    id_enter();
    prog(16'h0070, 8'h33);
    id_exit();
    idle(P);
    rd_check("R7 exit ignored while busy", 16'h0000, 8'hBF);
    id_exit();
    rd_check("R7 program in id mode", 16'h0070, 8'h33);
  endtask

  task automatic t_inhibit();
    unlock();
    wr(16'h5555, 8'hA0);
    bus(1'b1, 1'b1, 1'b0, 16'h0005, 8'h00);
    bus(1'b0, 1'b0, 1'b0, 16'h0005, 8'h00);
    wr(16'h0006, 8'hC3);
    idle(P);
    rd_check("R8 inhibited write no effect", 16'h0005, 8'hFF);
    rd_check("R8 sequence survived", 16'h0006, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_program();
    t_prog_status();
    t_busy_len();
    t_sector();
    t_chip();
    t_abort();
    t_id();
    t_inhibit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule